// File: doc/BRIEF.md
# Flash Row Write Buffer Controller

This block is the target-side write path of a small program flash. A host feeds it 16-bit words, one strobe per word. Each accepted word fills two bytes of a 64-byte staging buffer at the offset given by the current byte pointer, and the pointer then moves on by two. A second strobe loads one last word in the same way and then commits the whole staging buffer to the aligned 64-byte flash block that held the pointer when that word was loaded. The commit is internally timed: a busy flag stays high for a fixed, parameterized number of cycles, and the flash contents change when it drops.

The staging buffer is never cleared. Any offset the host does not rewrite carries its previous byte into the next commit, so a caller that wants a location left erased loads FFFFh there. Each block may be programmed only once between erases. A commit on an already programmed block is refused and flagged. A commit whose block differs from the block of the most recent plain load is also refused and flagged. Row erase clears a row of blocks around the pointer, and bulk erase clears the whole array. Both restore all-ones content and clear the programmed-once marks. Bytes are read back through a combinational read port.

Top module: `flash_wbuf_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, busy and both violation flags are 0, every flash byte reads FFh and the pointer is 0.
- R2: An accepted word places data bits 7:0 at buffer offset (pointer mod 64) with bit 0 forced to 0, and bits 15:8 at the next odd offset. It then adds 2 to the pointer, wrapping at the array size. Both plain and committing words do this.
- R3: An accepted committing word whose block is clean and consistent raises busy on the next cycle for exactly PROG_CYCLES cycles. At the edge where busy falls, all 64 bytes of block (pointer / 64), taken before the increment, are replaced by the buffer. No other block changes.
- R4: The buffer keeps its contents across commits, so offsets not reloaded since an earlier load are written again with that earlier data. After reset the buffer holds FFh everywhere.
- R5: With the write-enable input low, word strobes, commit strobes and erase requests have no effect on the buffer, the pointer, the flash, busy or the flags.
- R6: While busy is high, word strobes, pointer loads and erase requests are ignored, and the violation flags hold.
- R7: A committing word aimed at a block that has been programmed since its last erase sets the endurance flag. It leaves busy low and the flash unchanged.
- R8: A committing word whose block differs from the block of the last plain load since the previous commit attempt sets the region flag and is not programmed.
- R9: An accepted row erase sets to FFh every byte of the row of ROW_BLKS blocks that contains the pointer (row = pointer / (64*ROW_BLKS)), clears the programmed-once marks of those blocks, and leaves other rows alone.
- R10: An accepted bulk erase sets every flash byte to FFh and clears every programmed-once mark. Bulk erase wins over a row erase in the same cycle.
- R11: Both violation flags are updated on every accepted committing word and keep their value until the next one, so a successful commit clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_enable | input | 1 | Write-enable level; gates word loads, commits and erases |
| ptr_load | input | 1 | Load the byte pointer from ptr_value (ignored while busy) |
| ptr_value | input | ADDR_W | New byte pointer |
| word_data | input | 16 | Word to stage in the buffer |
| word_wr | input | 1 | Stage one word and advance the pointer |
| word_wr_start | input | 1 | Stage one word, advance the pointer and commit the buffer |
| erase_row | input | 1 | Erase the row containing the pointer |
| erase_bulk | input | 1 | Erase the whole array |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Flash byte at rd_addr, combinational |
| busy | output | 1 | Program operation in progress |
| endur_viol | output | 1 | Last commit attempt targeted an already programmed block |
| region_viol | output | 1 | Last commit attempt left the block of the staged data |

## Verification
The flags and busy change at the edge that samples an accepted committing word. The bench therefore checks them at the falling edge that follows that strobe. It then checks busy at each later falling edge: it must be high at PROG_CYCLES of them and low at the next. New flash contents and erased bytes appear at the edge after the operation completes. Reads are combinational, so the scoreboard drives an address just after a rising edge and compares the byte at the next falling edge. Expected bytes come from a bench-side model of the buffer, the pointer and the programmed-once marks.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef logic [7:0]  fbyte_t;
  typedef logic [15:0] fword_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PROG = 1'b1
  } seq_st_t;

  localparam fbyte_t ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/fwb_buffer.sv
// Staging buffer and byte pointer.
module fwb_buffer
  import fwb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int BLK_AW = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ptr_ld_i,
  input  logic [ADDR_W-1:0]          ptr_val_i,
  input  logic                       word_ld_i,
  input  fword_t                     word_i,
  output logic [ADDR_W-1:0]          ptr_o,
  output logic [(1<<BLK_AW)*8-1:0]   buf_o
);
  localparam int BLK_BYTES = 1 << BLK_AW;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  fbyte_t            buf_q [BLK_BYTES];
  fbyte_t            buf_d [BLK_BYTES];
  logic [BLK_AW-1:0] lo_off, hi_off;

  assign lo_off = {ptr_q[BLK_AW-1:1], 1'b0};
  assign hi_off = {ptr_q[BLK_AW-1:1], 1'b1};

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_ld_i)       ptr_d = ptr_val_i;
    else if (word_ld_i) ptr_d = ptr_q + ADDR_W'(2);
  end

  always_comb begin
    for (int i = 0; i < BLK_BYTES; i++) buf_d[i] = buf_q[i];
    if (word_ld_i && !ptr_ld_i) begin
      buf_d[lo_off] = word_i[7:0];
      buf_d[hi_off] = word_i[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < BLK_BYTES; i++) buf_q[i] <= ERASED_BYTE;
    end else begin
      ptr_q <= ptr_d;
      for (int i = 0; i < BLK_BYTES; i++) buf_q[i] <= buf_d[i];
    end
  end

  assign ptr_o = ptr_q;

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_flat
    assign buf_o[g*8 +: 8] = buf_q[g];
  end
endmodule

// File: rtl/fwb_seq.sv
// Commit sequencer: consistency checks, violation flags and program timer.
module fwb_seq
  import fwb_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BLK_AW      = 6,
  parameter int PROG_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       word_acc_i,
  input  logic                       start_acc_i,
  input  logic [ADDR_W-BLK_AW-1:0]   cur_blk_i,
  input  logic                       blk_used_i,
  output logic                       busy_o,
  output logic                       mark_o,
  output logic                       commit_o,
  output logic [ADDR_W-BLK_AW-1:0]   commit_blk_o,
  output logic                       endur_o,
  output logic                       region_o
);
  localparam int BLK_W = ADDR_W - BLK_AW;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] cblk_q, cblk_d, lblk_q, lblk_d;
  logic             have_q, have_d;
  logic             endur_q, endur_d, region_q, region_d;
  logic             mism, go;

  assign mism = have_q && (lblk_q != cur_blk_i);
  assign go   = start_acc_i && !mism && !blk_used_i;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    cblk_d   = cblk_q;
    lblk_d   = lblk_q;
    have_d   = have_q;
    endur_d  = endur_q;
    region_d = region_q;
    case (st_q)
      SEQ_IDLE: if (go) begin
        st_d   = SEQ_PROG;
        cnt_d  = CNT_W'(PROG_CYCLES - 1);
        cblk_d = cur_blk_i;
      end
      SEQ_PROG: begin
        if (cnt_q == '0) st_d = SEQ_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = SEQ_IDLE;
    endcase
    if (start_acc_i) begin
      endur_d  = blk_used_i;
      region_d = mism;
      have_d   = 1'b0;
    end else if (word_acc_i) begin
      have_d = 1'b1;
      lblk_d = cur_blk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      cnt_q    <= '0;
      cblk_q   <= '0;
      lblk_q   <= '0;
      have_q   <= 1'b0;
      endur_q  <= 1'b0;
      region_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      cblk_q   <= cblk_d;
      lblk_q   <= lblk_d;
      have_q   <= have_d;
      endur_q  <= endur_d;
      region_q <= region_d;
    end
  end

  assign busy_o       = (st_q == SEQ_PROG);
  assign commit_o     = busy_o && (cnt_q == '0);
  assign mark_o       = go;
  assign commit_blk_o = cblk_q;
  assign endur_o      = endur_q;
  assign region_o     = region_q;
endmodule

// File: rtl/fwb_array.sv
// Register-based flash array with per-block programmed-once marks.
module fwb_array
  import fwb_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int BLK_AW   = 6,
  parameter int ROW_BLKS = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       commit_i,
  input  logic [ADDR_W-BLK_AW-1:0]                   commit_blk_i,
  input  logic [(1<<BLK_AW)*8-1:0]                   buf_i,
  input  logic                                       mark_i,
  input  logic [ADDR_W-BLK_AW-1:0]                   mark_blk_i,
  input  logic                                       erase_row_i,
  input  logic                                       erase_bulk_i,
  input  logic [ADDR_W-BLK_AW-$clog2(ROW_BLKS)-1:0]  row_sel_i,
  input  logic [ADDR_W-1:0]                          rd_addr_i,
  input  logic [ADDR_W-BLK_AW-1:0]                   query_blk_i,
  output fbyte_t                                     rd_data_o,
  output logic                                       used_o
);
  localparam int NBYTES    = 1 << ADDR_W;
  localparam int BLK_BYTES = 1 << BLK_AW;
  localparam int BLK_W     = ADDR_W - BLK_AW;
  localparam int NBLK      = 1 << BLK_W;
  localparam int ROW_SH    = $clog2(ROW_BLKS);
  localparam int ROW_AW    = BLK_AW + ROW_SH;

  fbyte_t          mem_q [NBYTES];
  fbyte_t          mem_d [NBYTES];
  logic [NBLK-1:0] used_q, used_d;

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      mem_d[i] = mem_q[i];
      if (erase_bulk_i)
        mem_d[i] = ERASED_BYTE;
      else if (erase_row_i && ((ADDR_W'(i) >> ROW_AW) == ADDR_W'(row_sel_i)))
        mem_d[i] = ERASED_BYTE;
      else if (commit_i && ((ADDR_W'(i) >> BLK_AW) == ADDR_W'(commit_blk_i)))
        mem_d[i] = buf_i[(i % BLK_BYTES)*8 +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < NBLK; b++) begin
      used_d[b] = used_q[b];
      if (erase_bulk_i)
        used_d[b] = 1'b0;
      else if (erase_row_i && ((BLK_W'(b) >> ROW_SH) == BLK_W'(row_sel_i)))
        used_d[b] = 1'b0;
      else if (mark_i && (BLK_W'(b) == mark_blk_i))
        used_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int i = 0; i < NBYTES; i++) mem_q[i] <= ERASED_BYTE;
    end else begin
      used_q <= used_d;
      for (int i = 0; i < NBYTES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
  assign used_o    = used_q[query_blk_i];
endmodule

// File: rtl/flash_wbuf_ctrl.sv
// Top: flash row write buffer controller.
module flash_wbuf_ctrl
  import fwb_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int ROW_BLKS    = 2,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_enable,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_value,
  input  logic [15:0]       word_data,
  input  logic              word_wr,
  input  logic              word_wr_start,
  input  logic              erase_row,
  input  logic              erase_bulk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              endur_viol,
  output logic              region_viol
);
  localparam int BLK_AW    = 6;
  localparam int BLK_BYTES = 1 << BLK_AW;
  localparam int BLK_W     = ADDR_W - BLK_AW;
  localparam int ROW_AW    = BLK_AW + $clog2(ROW_BLKS);

  logic [ADDR_W-1:0]        ptr;
  logic [BLK_BYTES*8-1:0]   buf_flat;
  logic [BLK_W-1:0]         cur_blk, commit_blk;
  logic [ADDR_W-ROW_AW-1:0] row_sel;
  logic ptr_acc, any_word, word_acc, start_acc, plain_acc;
  logic erase_ok, bulk_acc, row_acc;
  logic blk_used, mark, commit;

  assign cur_blk   = ptr[ADDR_W-1:BLK_AW];
  assign row_sel   = ptr[ADDR_W-1:ROW_AW];
  assign ptr_acc   = ptr_load && !busy;
  assign any_word  = word_wr || word_wr_start;
  assign word_acc  = any_word && wr_enable && !busy && !ptr_load;
  assign start_acc = word_acc && word_wr_start;
  assign plain_acc = word_acc && !word_wr_start;
  assign erase_ok  = wr_enable && !busy && !any_word && !ptr_load;
  assign bulk_acc  = erase_bulk && erase_ok;
  assign row_acc   = erase_row && !erase_bulk && erase_ok;

  fwb_buffer #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_ld_i  (ptr_acc),
    .ptr_val_i (ptr_value),
    .word_ld_i (word_acc),
    .word_i    (word_data),
    .ptr_o     (ptr),
    .buf_o     (buf_flat)
  );

  fwb_seq #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_acc_i   (plain_acc),
    .start_acc_i  (start_acc),
    .cur_blk_i    (cur_blk),
    .blk_used_i   (blk_used),
    .busy_o       (busy),
    .mark_o       (mark),
    .commit_o     (commit),
    .commit_blk_o (commit_blk),
    .endur_o      (endur_viol),
    .region_o     (region_viol)
  );

  fwb_array #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW), .ROW_BLKS(ROW_BLKS)) u_arr (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_i     (commit),
    .commit_blk_i (commit_blk),
    .buf_i        (buf_flat),
    .mark_i       (mark),
    .mark_blk_i   (cur_blk),
    .erase_row_i  (row_acc),
    .erase_bulk_i (bulk_acc),
    .row_sel_i    (row_sel),
    .rd_addr_i    (rd_addr),
    .query_blk_i  (cur_blk),
    .rd_data_o    (rd_data),
    .used_o       (blk_used)
  );
endmodule

// File: rtl/fwb_checker.sv
module fwb_checker #(
  parameter int PROG_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_enable,
  input logic       ptr_load,
  input logic       word_wr,
  input logic       word_wr_start,
  input logic       erase_bulk,
  input logic       busy,
  input logic       endur_viol,
  input logic       region_viol,
  input logic [7:0] rd_data
);
  localparam int RUN_W = $clog2(PROG_CYCLES + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  AST_RST_IDLE: assert property (@(posedge clk) !rst_n |-> (!busy && !endur_viol && !region_viol)); // R1
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (run_q < RUN_W'(PROG_CYCLES))); // R3
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (run_q == RUN_W'(PROG_CYCLES))); // R3
  AST_NO_WEN: assert property (@(posedge clk) disable iff (!rst_n) (!wr_enable && !busy) |=> !busy); // R5
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> ($stable(endur_viol) && $stable(region_viol))); // R6
  AST_START_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) (word_wr_start && wr_enable && !busy && !ptr_load) |=> (busy != (endur_viol || region_viol))); // R7
  AST_CLEAN_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (!endur_viol && !region_viol)); // R11
  AST_BULK_ERASED: assert property (@(posedge clk) disable iff (!rst_n) (erase_bulk && wr_enable && !busy && !ptr_load && !word_wr && !word_wr_start) |=> (rd_data == 8'hFF)); // R10
endmodule

bind flash_wbuf_ctrl fwb_checker #(.PROG_CYCLES(PROG_CYCLES)) u_fwb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_enable     (wr_enable),
  .ptr_load      (ptr_load),
  .word_wr       (word_wr),
  .word_wr_start (word_wr_start),
  .erase_bulk    (erase_bulk),
  .busy          (busy),
  .endur_viol    (endur_viol),
  .region_viol   (region_viol),
  .rd_data       (rd_data)
);

// File: tb/test_flash_wbuf_ctrl.sv
`timescale 1ns/1ps
module test_flash_wbuf_ctrl;
  localparam int ADDR_W = 9;
  localparam int NB     = 1 << ADDR_W;
  localparam int P      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_enable = 1'b0, ptr_load = 1'b0, word_wr = 1'b0, word_wr_start = 1'b0;
  logic erase_row = 1'b0, erase_bulk = 1'b0;
  logic [ADDR_W-1:0] ptr_value = '0, rd_addr = '0;
  logic [15:0] word_data = '0;
  logic [7:0]  rd_data;
  logic busy, endur_viol, region_viol;

  always #5 clk = ~clk;

  flash_wbuf_ctrl #(.ADDR_W(ADDR_W), .ROW_BLKS(2), .PROG_CYCLES(P)) i_flash_wbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_enable(wr_enable), .ptr_load(ptr_load),
    .ptr_value(ptr_value), .word_data(word_data), .word_wr(word_wr),
    .word_wr_start(word_wr_start), .erase_row(erase_row), .erase_bulk(erase_bulk),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .endur_viol(endur_viol), .region_viol(region_viol)
  );

  int errors = 0;
  int checks = 0;

  // bench model
  logic [7:0] ref_mem [NB];
  logic [7:0] ref_buf [64];
  bit ref_used [NB/64];
  int m_ptr = 0;
  bit m_have = 0;
  int m_lblk = 0;
  bit e_endur = 0, e_region = 0;

  typedef struct { int addr; logic [7:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q [$];

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, int'(rd_data), int'(it.exp), $sformatf("rd[%0d]", it.addr));
    end
  end

  task automatic read_chk(int a, string tag);
    sb_item_t it;
    rd_addr = ADDR_W'(a);
    it.addr = a; it.exp = ref_mem[a]; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic check_block(int blk, string tag);
    for (int i = 0; i < 64; i++) read_chk(blk*64 + i, tag);
  endtask

  task automatic ptr_to(int a);
    ptr_load = 1'b1; ptr_value = ADDR_W'(a);
    tick();
    ptr_load = 1'b0;
    m_ptr = a;
  endtask

  task automatic stage(logic [15:0] d);
    int off;
    off = (m_ptr % 64) & ~1;
    ref_buf[off]   = d[7:0];
    ref_buf[off+1] = d[15:8];
    m_ptr = (m_ptr + 2) % NB;
  endtask

  task automatic plain(logic [15:0] d);
    word_wr = 1'b1; word_data = d;
    tick();
    word_wr = 1'b0;
    if (wr_enable) begin
      m_have = 1; m_lblk = m_ptr / 64;
      stage(d);
    end
  endtask

  task automatic start_word(logic [15:0] d, bit intrude, string tag);
    int blk; bit ok; bit acc;
    acc = wr_enable;
    blk = m_ptr / 64;
    word_wr_start = 1'b1; word_data = d;
    tick();
    word_wr_start = 1'b0;
    ok = 0;
    if (acc) begin
      e_endur  = ref_used[blk];
      e_region = m_have && (m_lblk != blk);
      ok = !e_endur && !e_region;
      m_have = 0;
      stage(d);
    end
    @(negedge clk);
    chk(tag, int'(busy), int'(ok), "busy after commit strobe");
    chk(tag, int'(endur_viol), int'(e_endur), "endur_viol");
    chk(tag, int'(region_viol), int'(e_region), "region_viol");
    if (ok) begin
      for (int i = 1; i < P; i++) begin
        @(negedge clk);
        if (intrude && i == 2) begin
          word_wr = 1'b1; word_data = 16'hDEAD;
          ptr_load = 1'b1; ptr_value = '0; erase_bulk = 1'b1;
        end
        if (intrude && i == 3) begin
          word_wr = 1'b0; ptr_load = 1'b0; erase_bulk = 1'b0;
        end
        chk("R3", int'(busy), 1, $sformatf("busy cycle %0d", i));
      end
      @(negedge clk);
      chk("R3", int'(busy), 0, "busy dropped");
      for (int i = 0; i < 64; i++) ref_mem[blk*64 + i] = ref_buf[i];
      ref_used[blk] = 1;
    end
    @(posedge clk); #1;
  endtask

  task automatic erase(bit bulk);
    int r;
    if (bulk) erase_bulk = 1'b1; else erase_row = 1'b1;
    tick();
    erase_bulk = 1'b0; erase_row = 1'b0;
    if (wr_enable) begin
      if (bulk) begin
        for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
        for (int b = 0; b < NB/64; b++) ref_used[b] = 0;
      end else begin
        r = m_ptr / 128;
        for (int i = r*128; i < r*128 + 128; i++) ref_mem[i] = 8'hFF;
        ref_used[2*r] = 0; ref_used[2*r+1] = 0;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) ref_mem[i] = 8'hFF;
    for (int i = 0; i < 64; i++) ref_buf[i] = 8'hFF;
    for (int b = 0; b < NB/64; b++) ref_used[b] = 0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(busy), 0, "busy in reset");
    chk("R1", int'(endur_viol), 0, "endur in reset");
    chk("R1", int'(region_viol), 0, "region in reset");
    rst_n = 1'b1;
    tick();
    check_block(0, "R1");
    check_block(7, "R1");

    // R2, R3: fill block 1 and commit
    wr_enable = 1'b1;
    ptr_to(64);
    for (int i = 0; i < 31; i++) plain(16'h1234 + 16'(i) * 16'h0101);
    start_word(16'hA55A, 1'b0, "R3");
    check_block(1, "R2");
    check_block(0, "R3");
    check_block(2, "R3");

    // R7: second program of block 1
    ptr_to(64);
    start_word(16'h0F0F, 1'b0, "R7");
    check_block(1, "R7");

    // R4, R11, R6: partial load of block 2, stale bytes reused, intrusion while busy
    ptr_to(128);
    plain(16'hBEEF);
    plain(16'hC0DE);
    start_word(16'h7711, 1'b1, "R11");
    check_block(2, "R4");
    check_block(1, "R6");
    // pointer must still be 134 (block 2, programmed): refused
    start_word(16'h2222, 1'b0, "R6");

    // R8: load in block 3, commit in block 4
    ptr_to(192);
    plain(16'h3344);
    ptr_to(256);
    start_word(16'h5566, 1'b0, "R8");
    check_block(4, "R8");

    // R5: write enable low
    wr_enable = 1'b0;
    ptr_to(320);
    start_word(16'h9999, 1'b0, "R5");
    plain(16'h8888);
    erase(1'b1);
    check_block(5, "R5");
    check_block(1, "R5");

    // R9: row erase of row 0 (blocks 0,1), block 2 kept, block 1 reprogrammable
    wr_enable = 1'b1;
    ptr_to(64);
    erase(1'b0);
    check_block(1, "R9");
    check_block(2, "R9");
    start_word(16'h6161, 1'b0, "R9");
    check_block(1, "R9");

    // R10: bulk erase, block 2 reprogrammable
    erase(1'b1);
    check_block(1, "R10");
    check_block(2, "R10");
    ptr_to(128);
    start_word(16'h4242, 1'b0, "R10");
    check_block(2, "R10");

    repeat (3) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule